// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a small timer that can run as an interval timer or as a watchdog. A 3-bit clock-select field picks one of three power-of-two prescaler taps. Each prescaled tick advances an 8-bit up-counter. When the counter wraps from 0xFF to 0x00, the mode bit decides what happens. In interval mode the wrap sets a sticky overflow flag. In watchdog mode it sends out a one-clock reset request and sets a sticky bit that records a watchdog-caused reset.

Software reaches two byte-wide registers through a single 16-bit write port. `wr_sel` chooses the register: 0 is control/status, 1 is the counter. A write takes effect only when the upper byte of `wr_data` equals the key `KEY`, so a stray bus write cannot stop or reload the timer. Both registers can always be read directly. A normal start sequence is: write the counter to zero, then write control with the enable bit set. Servicing the watchdog means rewriting the counter before it wraps.

The parameter `TAP_LOW` sets log2 of the smallest divisor. With the default of 10, codes 5, 6 and 7 divide the clock by 1024, 2048 and 4096.

Top module: `wdt_prescaled`

## Requirements
- R1: After power-on reset (`rst_n` low) the control byte reads 0x07, the counter reads 0x00 and `rst_req` is 0.
- R2: A write whose `wr_data[15:8]` differs from `KEY` (default 0xA5) changes neither register.
- R3: The control byte layout is bit7 overflow flag, bit6 mode (1 = watchdog), bit5 enable, bit4 watchdog-reset status, bit3 reads 0, and bits2:0 clock select. A keyed write with clock select 5, 6 or 7 stores that code, giving a divisor of 2^(TAP_LOW+code-5). Any other code leaves the field unchanged, while the rest of the write still applies.
- R4: While enabled, the counter advances once every divisor clocks. The prescaler clears when enable goes from 0 to 1, so the first increment lands exactly one divisor after the enabling write.
- R5: With enable at 0 the counter holds its value.
- R6: A keyed write to the counter register loads `wr_data[7:0]` and restarts the prescaler from zero.
- R7: In interval mode, a tick at count 0xFF wraps the counter to 0x00 and sets the overflow flag (bit7). `rst_req` stays 0.
- R8: The overflow flag stays set until a keyed control write with bit7 = 0. Writing bit7 = 1 leaves it unchanged. If an overflow and a clearing write fall in the same clock, the overflow wins.
- R9: In watchdog mode, the wrap drives `rst_req` high for exactly one clock, in the cycle after the wrapping edge. The overflow flag is not set.
- R10: A watchdog-mode wrap sets bit4. Bit4 is cleared only by power-on reset or by a keyed control write with bit4 = 0. Writing 1 to bit4 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_sel | input | 1 | 0 selects control/status, 1 selects counter |
| wr_data | input | 16 | Key in bits 15:8, register value in bits 7:0 |
| ctrl_rd | output | 8 | Current control/status byte |
| cnt_rd | output | 8 | Current counter value |
| rst_req | output | 1 | One-clock watchdog reset request |

## Verification
The counter is swept over a full 256-tick period for each of the three legal clock-select codes. This is checked against count = floor(cycles/divisor) mod 256 on every clock, which tells apart a wrong tap, an off-by-one first tick and a missed wrap. The five illegal codes and writes with a wrong key are each tried once, to show that only a correct key with a legal code alters state. A freeze-and-resume pattern separates "hold while disabled" from "prescaler cleared on restart". A counter preload near 0xFF in watchdog mode checks where the one-clock reset pulse falls and how the sticky status bit behaves under writes of 1 and of 0.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int         TAP_LOW = 10,
  parameter logic [7:0] KEY     = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  output logic [7:0]  ctrl_rd,
  output logic [7:0]  cnt_rd,
  output logic        rst_req
);
  localparam int PW = TAP_LOW + 2;

  logic          en_q, mode_q, ovf_q, stat_q;
  logic [2:0]    cks_q;
  logic [7:0]    cnt_q;
  logic [PW-1:0] pre_q, mask;

  logic key_ok, ctrl_wr, cnt_wr, cks_legal, en_rise, tick, wrap;

  assign key_ok    = wr_en && (wr_data[15:8] == KEY);
  assign ctrl_wr   = key_ok && !wr_sel;
  assign cnt_wr    = key_ok && wr_sel;
  assign cks_legal = wr_data[2:0] >= 3'd5;
  assign en_rise   = ctrl_wr && wr_data[5] && !en_q;
  assign mask      = {PW{1'b1}} >> (3'd7 - cks_q);
  assign tick      = en_q && ((pre_q & mask) == mask);
  assign wrap      = tick && (cnt_q == 8'hFF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre_q <= '0;
    else if (en_rise || cnt_wr) pre_q <= '0;
    else if (en_q)             pre_q <= pre_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_q <= 8'h00;
    else if (cnt_wr)  cnt_q <= wr_data[7:0];
    else if (tick)    cnt_q <= cnt_q + 8'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      cks_q  <= 3'd7;
    end else if (ctrl_wr) begin
      en_q   <= wr_data[5];
      mode_q <= wr_data[6];
      if (cks_legal) cks_q <= wr_data[2:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        ovf_q <= 1'b0;
    else if (wrap && !mode_q)          ovf_q <= 1'b1;
    else if (ctrl_wr && !wr_data[7])   ovf_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        stat_q <= 1'b0;
    else if (wrap && mode_q)           stat_q <= 1'b1;
    else if (ctrl_wr && !wr_data[4])   stat_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= wrap && mode_q;

  assign ctrl_rd = {ovf_q, mode_q, en_q, stat_q, 1'b0, cks_q};
  assign cnt_rd  = cnt_q;

  // R9: reset request lasts one clock
  a_r9_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R9: request only follows a watchdog-mode wrap to zero
  a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(mode_q) && cnt_q == 8'h00));

  // R10: status recorded together with the request
  a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> stat_q);

  // R5: disabled counter holds unless loaded
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));

  // R8: flag survives anything but a control write
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ctrl_wr) |=> ovf_q);

  // R3: only legal codes ever held
  a_r3_legal_sel: assert property (@(posedge clk) disable iff (!rst_n)
    cks_q >= 3'd5);
endmodule

// File: tb/test_wdt_prescaled.sv
`timescale 1ns/1ps
module test_wdt_prescaled;
  localparam int         TAP = 1;
  localparam logic [7:0] KEY = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [7:0]  ctrl_rd, cnt_rd;
  logic        rst_req;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdt_prescaled #(.TAP_LOW(TAP), .KEY(KEY)) i_wdt_prescaled (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_rd(ctrl_rd), .cnt_rd(cnt_rd), .rst_req(rst_req));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_rd, 8'h07);
    chk("R1 cnt", cnt_rd, 8'h00);
    chk("R1 req", {7'b0, rst_req}, 8'h00);

    // R2: wrong key
    wr(1'b0, 16'h1225);
    chk("R2 ctrl", ctrl_rd, 8'h07);
    wr(1'b1, 16'h3C44);
    chk("R2 cnt", cnt_rd, 8'h00);

    // R3: illegal codes keep the select field
    for (int c = 0; c < 5; c++) begin
      wr(1'b0, {KEY, 5'b0, 3'(c)});
      chk("R3 illegal code", ctrl_rd, 8'h07);
    end

    // R4/R7/R8: full-period sweep per legal code
    for (int code = 5; code <= 7; code++) begin
      int div;
      div = 2 << (code - 5);
      wr(1'b1, {KEY, 8'h00});
      wr(1'b0, {KEY, 8'h20 | 8'(code)});
      chk("R3 legal code", ctrl_rd, 8'h20 | 8'(code));
      for (int j = 1; j <= 256 * div; j++) begin
        @(negedge clk);
        chk("R4 count", cnt_rd, 8'((j / div) % 256));
        chk("R7 no request", {7'b0, rst_req}, 8'h00);
        chk("R7 flag", {7'b0, ctrl_rd[7]}, (j == 256 * div) ? 8'h01 : 8'h00);
      end
      repeat (3) @(negedge clk);
      chk("R8 sticky", {7'b0, ctrl_rd[7]}, 8'h01);
      wr(1'b0, {KEY, 8'hA0 | 8'(code)});
      chk("R8 write one", {7'b0, ctrl_rd[7]}, 8'h01);
      wr(1'b0, {KEY, 8'h20 | 8'(code)});
      chk("R8 clear", {7'b0, ctrl_rd[7]}, 8'h00);
      wr(1'b0, {KEY, 8'(code)});
    end

    // R5: freeze and resume, divisor 2
    wr(1'b1, {KEY, 8'h00});
    wr(1'b0, {KEY, 8'h25});
    repeat (5) @(negedge clk);
    chk("R4 partial", cnt_rd, 8'h02);
    wr(1'b0, {KEY, 8'h05});
    chk("R5 last tick", cnt_rd, 8'h03);
    repeat (20) @(negedge clk);
    chk("R5 frozen", cnt_rd, 8'h03);
    wr(1'b0, {KEY, 8'h25});
    chk("R4 restart", cnt_rd, 8'h03);
    @(negedge clk);
    chk("R4 restart first tick early", cnt_rd, 8'h03);
    @(negedge clk);
    chk("R4 restart first tick", cnt_rd, 8'h04);

    // R6: load restarts prescaler
    @(negedge clk);
    wr(1'b1, {KEY, 8'h80});
    chk("R6 load", cnt_rd, 8'h80);
    @(negedge clk);
    chk("R6 hold", cnt_rd, 8'h80);
    @(negedge clk);
    chk("R6 tick", cnt_rd, 8'h81);

    // R9/R10: watchdog mode wrap
    wr(1'b0, {KEY, 8'h05});
    wr(1'b1, {KEY, 8'hFE});
    wr(1'b0, {KEY, 8'h65});
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      chk("R9 request", {7'b0, rst_req}, (j == 4) ? 8'h01 : 8'h00);
      if (j == 4) begin
        chk("R9 wrap", cnt_rd, 8'h00);
        chk("R10 status set", ctrl_rd, 8'h75);
      end
    end
    chk("R10 status held", ctrl_rd, 8'h75);
    wr(1'b0, {KEY, 8'h55});
    chk("R10 write one", ctrl_rd, 8'h55);
    wr(1'b0, {KEY, 8'h45});
    chk("R10 clear", ctrl_rd, 8'h45);

    // R10/R1: power-on reset clears status
    wr(1'b0, {KEY, 8'h65});
    wr(1'b1, {KEY, 8'hFF});
    repeat (3) @(negedge clk);
    chk("R10 set again", {7'b0, ctrl_rd[4]}, 8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", ctrl_rd, 8'h07);
    chk("R1 cnt after reset", cnt_rd, 8'h00);
    finish_run();
  end
endmodule